// File: doc/BRIEF.md
# Programmable trigger delay and shutter generator

This block sits in a trigger processor that runs on the 40 MHz clock shared by the calorimeter electronics and a pixel-detector front-end. A master trigger pulse from the beam facility arrives asynchronously. It is brought into the clock domain and reduced to a single start strobe. That strobe launches three timed outputs. The first is a calorimeter T0 pulse and the second is a pixel-detector trigger pulse, each after its own programmable delay. The third is a shutter gate for the pixel detector, with its own start delay and width.

A busy level from the pixel front-end blocks new sequences. A master trigger that arrives while busy is high, or while an earlier sequence is still running, starts nothing and increments a rejected-trigger counter. Four 16-bit timing registers are loaded through a write-only register port. Writes are accepted only while no sequence is running, so a sequence in flight keeps the timing it started with.

Top module: `trig_shutter_gen`

## Requirements
- R1: After reset, cal_trig_o is 0, pix_trig_no is 1, shutter_o is 0 and rej_cnt_o is 0.
- R2: A master trigger held high for many cycles starts exactly one sequence. A new sequence needs a fresh low-to-high transition.
- R3: cal_trig_o is high for exactly one cycle. If master_trig_i is driven high just after clock edge k, the pulse is high in the cycle that follows edge k+3+D, where D is the calorimeter delay register (address 0, value in clock cycles; 0 means the cycle after the start strobe).
- R4: pix_trig_no is active-low and low for exactly one cycle. It follows edge k+3+P, where P is the pixel delay register (address 1).
- R5: shutter_o is high for W+1 consecutive cycles. The first of them follows edge k+3+S, where S is the shutter delay register (address 2) and W is the shutter width register (address 3).
- R6: A master trigger whose start strobe meets busy_i high produces no output pulse and increments rej_cnt_o by one.
- R7: A master trigger whose start strobe arrives while any output of an earlier sequence is still pending or active is ignored. It increments rej_cnt_o by one and leaves the running sequence's timing unchanged.
- R8: A register write (cfg_we_i high, cfg_addr_i selecting the register, cfg_wdata_i the value) made while a sequence is running is dropped. A write made while idle takes effect for the next sequence.
- R9: The three delays are independent: changing one register moves only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz clock shared with the front-ends |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_trig_i | input | 1 | Asynchronous master trigger from the beam facility |
| busy_i | input | 1 | Busy level from the pixel front-end |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register select: 0 cal delay, 1 pixel delay, 2 shutter delay, 3 shutter width |
| cfg_wdata_i | input | 16 | Register write data in clock cycles |
| cal_trig_o | output | 1 | Calorimeter T0 pulse, active-high, one cycle |
| pix_trig_no | output | 1 | Pixel trigger pulse, active-low, one cycle |
| shutter_o | output | 1 | Pixel shutter gate, active-high |
| rej_cnt_o | output | 16 | Count of rejected master triggers, wrapping |

## Verification
The timing function is swept over combinations of calorimeter delay, pixel delay, shutter delay and shutter width in a small range that includes zero. For every combination, the bench checks the arrival cycle and the pulse length of each output against arithmetic from the register values. This sweep separates an off-by-one in the delay count from one in the width count, and it also exposes any coupling between channels. A large pixel delay checks that the full counter width is used. Targeted patterns separate the three ways a master trigger can fail to start a sequence: busy high, a sequence still running, or the trigger simply being held high. Each of these is checked through the outputs and the reject count. A write made during a running sequence is shown to have been dropped by the timing of the next sequence.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam int CFG_AW = 2;
  localparam logic [CFG_AW-1:0] ADDR_CAL_DLY = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_PIX_DLY = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_SHT_DLY = 2'd2;
  localparam logic [CFG_AW-1:0] ADDR_SHT_WID = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/tdg_sync_edge.sv
module tdg_sync_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic strobe_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], async_i};
  end

  // rising edge of the synchronized level
  assign strobe_o = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];

  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/tdg_timer.sv
module tdg_timer
  import tdg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             active_o
);
  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          cnt_q   <= delay_i;
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            if (width_i == '0) state_q <= ST_IDLE;
            else begin
              state_q <= ST_HOLD;
              cnt_q   <= width_i - CNT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // first output cycle is the last wait cycle
  assign pulse_o  = ((state_q == ST_WAIT) && (cnt_q == '0)) || (state_q == ST_HOLD);
  assign active_o = (state_q != ST_IDLE);

  p_ends_on_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(pulse_o));
  p_start_only_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !pulse_o) |=> active_o);
endmodule

// File: rtl/trig_shutter_gen.sv
module trig_shutter_gen
  import tdg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REJ_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_trig_i,
  input  logic              busy_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  output logic              cal_trig_o,
  output logic              pix_trig_no,
  output logic              shutter_o,
  output logic [REJ_W-1:0]  rej_cnt_o
);
  localparam int NCH  = 3;
  localparam int NREG = 1 << CFG_AW;

  logic [NREG-1:0][CNT_W-1:0] cfg_q;
  logic [NCH-1:0][CNT_W-1:0]  ch_dly, ch_wid;
  logic [NCH-1:0]             ch_pulse, ch_active;
  logic                       strobe, all_idle, accept;
  logic [REJ_W-1:0]           rej_q;

  tdg_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(master_trig_i), .strobe_o(strobe)
  );

  assign all_idle = ~|ch_active;
  assign accept   = strobe & all_idle & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_we_i && all_idle && !accept) cfg_q[cfg_addr_i] <= cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rej_q <= '0;
    else if (strobe && !accept) rej_q <= rej_q + REJ_W'(1);
  end

  // channel 0 cal, 1 pixel trigger, 2 shutter
  assign ch_dly[0] = cfg_q[ADDR_CAL_DLY];
  assign ch_dly[1] = cfg_q[ADDR_PIX_DLY];
  assign ch_dly[2] = cfg_q[ADDR_SHT_DLY];
  assign ch_wid[0] = '0;
  assign ch_wid[1] = '0;
  assign ch_wid[2] = cfg_q[ADDR_SHT_WID];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tdg_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (accept),
      .delay_i (ch_dly[c]),
      .width_i (ch_wid[c]),
      .pulse_o (ch_pulse[c]),
      .active_o(ch_active[c])
    );
  end

  assign cal_trig_o  = ch_pulse[0];
  assign pix_trig_no = ~ch_pulse[1];
  assign shutter_o   = ch_pulse[2];
  assign rej_cnt_o   = rej_q;

  p_cal_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_trig_o |=> !cal_trig_o);
  p_pix_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_trig_no |=> pix_trig_no);
  p_busy_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && busy_i) |=> (rej_cnt_o == REJ_W'($past(rej_cnt_o) + 1'b1)));
  p_run_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !all_idle) |=> (rej_cnt_o == REJ_W'($past(rej_cnt_o) + 1'b1)));
  p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_idle |=> $stable(cfg_q));
endmodule

// File: tb/trig_shutter_gen_test.sv
module trig_shutter_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mtrig = 1'b0, busy = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        cal, pix_n, sht;
  logic [15:0] rej;

  int cyc = 0, t0 = 0;
  int n_chk = 0, n_fail = 0;
  int cal_n, cal_at, pix_n_cnt, pix_at, sh_n, sh_first, sh_last;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_shutter_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .master_trig_i(mtrig), .busy_i(busy),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cal_trig_o(cal), .pix_trig_no(pix_n), .shutter_o(sht), .rej_cnt_o(rej)
  );

  always @(negedge clk) begin
    if (cal) begin if (cal_n == 0) cal_at = cyc - t0; cal_n++; end
    if (!pix_n) begin if (pix_n_cnt == 0) pix_at = cyc - t0; pix_n_cnt++; end
    if (sht) begin if (sh_n == 0) sh_first = cyc - t0; sh_last = cyc - t0; sh_n++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    step(1);
    we = 1'b1; addr = a; wdata = 16'(d);
    step(1);
    we = 1'b0;
  endtask

  task automatic fire();
    step(1);
    t0 = cyc;
    cal_n = 0; pix_n_cnt = 0; sh_n = 0;
    cal_at = -1; pix_at = -1; sh_first = -1; sh_last = -1;
    mtrig = 1'b1;
  endtask

  task automatic release_trig();
    mtrig = 1'b0;
    step(4);
  endtask

  initial begin
    step(3);
    // R1 reset state
    eq("R1 cal", int'(cal), 0);
    eq("R1 pix_n", int'(pix_n), 1);
    eq("R1 shutter", int'(sht), 0);
    eq("R1 rej", int'(rej), 0);
    rst_n = 1'b1;
    step(2);

    // sweep: R3 R4 R5 R9, trigger held high through window (R2)
    for (int cd = 0; cd < 4; cd++)
      for (int sd = 0; sd < 3; sd++)
        for (int sw = 0; sw < 4; sw++) begin
          int pd;
          pd = (cd * 2 + sd) % 5;
          wr(2'd0, cd); wr(2'd1, pd); wr(2'd2, sd); wr(2'd3, sw);
          fire();
          step(3 + 6 + sw + 6);
          eq("R3 cal cycle", cal_at, 3 + cd);
          eq("R3 cal length", cal_n, 1);
          eq("R4 pix cycle", pix_at, 3 + pd);
          eq("R4 pix length", pix_n_cnt, 1);
          eq("R5 shutter start", sh_first, 3 + sd);
          eq("R5 shutter length", sh_n, sw + 1);
          eq("R5 shutter end", sh_last, 3 + sd + sw);
          release_trig();
        end
    eq("R2 held trigger no rejects", int'(rej), 0);

    // large delay on one channel only: R9 and full width
    wr(2'd0, 1); wr(2'd1, 300); wr(2'd2, 2); wr(2'd3, 0);
    fire();
    step(310);
    eq("R9 pix large delay", pix_at, 303);
    eq("R9 cal unaffected", cal_at, 4);
    eq("R9 shutter unaffected", sh_first, 5);
    release_trig();

    // R6 busy rejects
    busy = 1'b1;
    fire();
    step(320);
    eq("R6 cal suppressed", cal_n, 0);
    eq("R6 pix suppressed", pix_n_cnt, 0);
    eq("R6 shutter suppressed", sh_n, 0);
    eq("R6 reject count", int'(rej), 1);
    release_trig();
    busy = 1'b0;

    // R7 retrigger while running, R8 write dropped during run
    wr(2'd0, 20); wr(2'd1, 1); wr(2'd2, 0); wr(2'd3, 0);
    fire();
    step(5);
    mtrig = 1'b0;
    step(3);
    mtrig = 1'b1;
    wr(2'd0, 2);
    step(20);
    eq("R7 cal once", cal_n, 1);
    eq("R7 cal timing kept", cal_at, 23);
    eq("R7 pix once", pix_n_cnt, 1);
    eq("R7 reject count", int'(rej), 2);
    release_trig();
    fire();
    step(26);
    eq("R8 write during run dropped", cal_at, 23);
    release_trig();
    wr(2'd0, 2);
    fire();
    step(10);
    eq("R8 idle write applied", cal_at, 5);
    release_trig();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule